// File: doc/BRIEF.md
# PCI Shared Interrupt Aggregator

This block gathers three local interrupt requests onto one level-sensitive, active-low PCI interrupt line that other devices may share. Two of the requests come from general-purpose input pins. Each pin has a programmable active sense and passes through a synchronizer. The third request is a synchronous request from a parallel-port controller. Each source has its own enable. A status field reports the level of every source after polarity correction and before masking.

A preloaded pin-select byte decides whether the function drives the shared line at all. Only the value 1 lets the line assert. This byte can change only through a dedicated load port, which a non-volatile configuration loader drives. Ordinary register writes cannot change it. The output is modelled as an open-drain driver: a data pin that is low whenever it drives, and an output enable.

Top module: `pci_irq_combiner`

## Requirements
- R1: After reset the enable bits are 0, the polarity bits are 0, the pin-select byte is 1 and `inta_oe` is low.
- R2: A write to register 0 sets the enables in bits [2:0] (bit 0 for pin 0, bit 1 for pin 1, bit 2 for the parallel-port request), and register 0 reads them back there. Bits 3 and 7 read 0, and writes to bits [6:4] have no effect.
- R3: Register 0 bits [6:4] read the polarity-corrected level of pin 0, pin 1 and the parallel-port request, whatever the enables hold.
- R4: Register 1 bits [1:0] hold the polarity of pin 0 and pin 1, where 1 means active-low. These bits read back, and the other bits read 0.
- R5: A change on a general-purpose pin appears in status and at the output after the second rising clock edge, and not after the first.
- R6: When any enabled source is active and the pin-select byte equals 1, `inta_oe` is high and `inta_n` is low. Otherwise `inta_oe` is low and `inta_n` is high.
- R7: A pin-select value of 0, and any reserved value from 2 to 255, keeps `inta_oe` low whatever the sources do.
- R8: The pin-select byte reads at register 2 and changes only on `pinsel_ld`. A register write to address 2 leaves it unchanged.
- R9: The output is not latched. It deasserts in the same cycle that the last enabled source goes inactive.
- R10: An active source whose enable is 0 never asserts the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register address: 0 interrupt enable/status, 1 polarity, 2 pin-select (read-only) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| gp_pin | input | 2 | Asynchronous general-purpose interrupt pins |
| lpt_req | input | 1 | Synchronous parallel-port interrupt request, active-high |
| pinsel_ld | input | 1 | Load strobe for the pin-select byte |
| pinsel_data | input | 8 | Pin-select value to load |
| inta_n | output | 1 | Open-drain data, low while driving |
| inta_oe | output | 1 | Open-drain output enable |

## Verification
The bench sets each pin-select value that matters: 1, 0 and a reserved value such as 2 or 255. A design that decoded only bit 0 of that byte would assert on odd reserved values, and a design that let register writes reach the byte would lose the suppression. The bench also inverts each pin's polarity while the pin is held, which catches a swapped polarity-to-pin mapping or an inverted sense. It checks the synchronizer latency one edge at a time, so a missing or extra stage shows up. The last source is dropped while the line is asserted, so a design that latched the interrupt would keep driving the shared line.

// File: rtl/pci_irq_combiner.sv
module pci_irq_combiner #(
  parameter int SYNC_DEPTH = 2,
  parameter logic [7:0] PINSEL_RESET = 8'd1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [1:0] gp_pin,
  input  logic       lpt_req,
  input  logic       pinsel_ld,
  input  logic [7:0] pinsel_data,
  output logic       inta_n,
  output logic       inta_oe
);

  localparam logic [1:0] SEL_GIR = 2'd0;
  localparam logic [1:0] SEL_POL = 2'd1;
  localparam logic [1:0] SEL_PIN = 2'd2;

  logic [2:0] en_q;
  logic [1:0] pol_q;
  logic [7:0] pinsel_q;
  logic [1:0] sync_q [SYNC_DEPTH];
  logic [2:0] src_lvl;
  logic       any_req;
  logic       route_ok;

  wire unused_wbits = ^reg_wdata[7:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_DEPTH; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= gp_pin;
      for (int i = 1; i < SYNC_DEPTH; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= '0;
    end else if (reg_wr) begin
      if (reg_sel == SEL_GIR) en_q  <= reg_wdata[2:0];
      if (reg_sel == SEL_POL) pol_q <= reg_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pinsel_q <= PINSEL_RESET;
    else if (pinsel_ld) pinsel_q <= pinsel_data;
  end

  assign src_lvl  = {lpt_req, sync_q[SYNC_DEPTH-1] ^ pol_q};
  assign any_req  = |(src_lvl & en_q);
  assign route_ok = (pinsel_q == 8'd1);
  assign inta_oe  = any_req & route_ok;
  assign inta_n   = ~inta_oe;

  always_comb begin
    case (reg_sel)
      SEL_GIR: reg_rdata = {1'b0, src_lvl, 1'b0, en_q};
      SEL_POL: reg_rdata = {6'b0, pol_q};
      SEL_PIN: reg_rdata = pinsel_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  AST_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n) inta_oe |-> !inta_n); // R6
  AST_PIN_GATE: assert property (@(posedge clk) disable iff (!rst_n) (pinsel_q != 8'd1) |-> !inta_oe); // R7
  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !pinsel_ld |=> $stable(pinsel_q)); // R8
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(reg_wr && reg_sel == SEL_GIR) |=> $stable(en_q)); // R2
  AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (en_q == 3'b000) |-> !inta_oe); // R10

endmodule

// File: tb/tb_pci_irq_combiner.sv
`timescale 1ns/1ps
module tb_pci_irq_combiner;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [1:0] gp_pin = 0;
  logic lpt_req = 0, pinsel_ld = 0;
  logic [7:0] pinsel_data = 0;
  logic inta_n, inta_oe;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  pci_irq_combiner dut (.*);

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1; reg_sel = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    reg_sel = a; #0.1; d = reg_rdata;
  endtask

  task automatic ld_pin(logic [7:0] v);
    pinsel_ld = 1; pinsel_data = v;
    tick();
    pinsel_ld = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(0, d); check("R1 gir", d, 8'h00);
    rd(1, d); check("R1 pol", d, 8'h00);
    rd(2, d); check("R1 pinsel", d, 8'h01);
    check("R1 oe", {7'b0, inta_oe}, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(0, 8'hFF); rd(0, d); check("R2 en readback, status ro", d, 8'h07);
    wr(0, 8'h05); rd(0, d); check("R2 en 101", d, 8'h05);
    wr(1, 8'hFE); rd(1, d); check("R4 pol readback", d, 8'h02);
    wr(1, 8'h00); wr(0, 8'h00);
  endtask

  task automatic t_sync;
    logic [7:0] d;
    wr(0, 8'h01);
    gp_pin = 2'b01;
    tick(); rd(0, d); check("R5 after 1 edge", d, 8'h01);
    check("R5 oe after 1 edge", {7'b0, inta_oe}, 8'h00);
    tick(); rd(0, d); check("R5 after 2 edges", d, 8'h11);
    check("R6 oe asserted", {6'b0, inta_oe, inta_n}, 8'h02);
    gp_pin = 2'b00; tick(2);
    check("R9 deassert", {6'b0, inta_oe, inta_n}, 8'h01);
  endtask

  task automatic t_polarity;
    logic [7:0] d;
    wr(0, 8'h00);
    gp_pin = 2'b00; tick(2);
    wr(1, 8'h02); rd(0, d); check("R4 pin1 active-low", d, 8'h20);
    check("R10 masked", {7'b0, inta_oe}, 8'h00);
    wr(1, 8'h01); rd(0, d); check("R3 pin0 active-low", d, 8'h10);
    wr(0, 8'h02); check("R10 pin1 enabled but inactive", {7'b0, inta_oe}, 8'h00);
    wr(0, 8'h01); check("R6 pin0 active-low drives", {7'b0, inta_oe}, 8'h01);
    gp_pin = 2'b11; tick(2); rd(0, d); check("R3 both pins", d, 8'h21);
    check("R9 pin0 released", {7'b0, inta_oe}, 8'h00);
    wr(1, 8'h00); wr(0, 8'h00); gp_pin = 0; tick(2);
  endtask

  task automatic t_lpt;
    logic [7:0] d;
    lpt_req = 1; #0.1; rd(0, d); check("R3 lpt status unmasked", d, 8'h40);
    check("R10 lpt disabled", {7'b0, inta_oe}, 8'h00);
    wr(0, 8'h04); check("R6 lpt drives", {7'b0, inta_oe}, 8'h01);
    lpt_req = 0; #0.1; check("R9 lpt same-cycle release", {7'b0, inta_oe}, 8'h00);
    lpt_req = 1;
  endtask

  task automatic t_pinsel;
    logic [7:0] d;
    ld_pin(8'd0); check("R7 pinsel 0", {7'b0, inta_oe}, 8'h00);
    ld_pin(8'd3); check("R7 pinsel 3", {7'b0, inta_oe}, 8'h00);
    ld_pin(8'd255); check("R7 pinsel 255", {7'b0, inta_oe}, 8'h00);
    wr(2, 8'h01); rd(2, d); check("R8 write ignored", d, 8'hFF);
    check("R8 still suppressed", {7'b0, inta_oe}, 8'h00);
    ld_pin(8'd1); rd(2, d); check("R8 load", d, 8'h01);
    check("R6 restored", {7'b0, inta_oe}, 8'h01);
    lpt_req = 0;
  endtask

  initial begin
    tick(2); #0.5; rst_n = 1; tick();
    t_reset();
    t_regs();
    t_sync();
    t_polarity();
    t_lpt();
    t_pinsel();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule